// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register

This block converts a parallel word into a serial bit stream. On a rising clock edge it either captures the whole word from its parallel inputs, or it moves every stage up by one position and takes a new bit from the serial input into stage 0. Only the most significant stage is driven out. An active-low enable freezes the register. An active-low reset clears it at once, with no clock edge needed.

Because the last stage feeds the serial input of a following unit, units can be chained into a longer converter. Two chained 8-bit units act as one 16-bit register. All sequential logic runs on one free-running clock. The enable is a synchronous qualifier and does not gate the clock.

Top module: `piso_shreg`

## Requirements
- R1: When `clkEnN` is 0 and `loadN` is 0 at a rising edge, `parIn` is copied into the register, with `parIn[i]` going to stage i. `serOut` then shows `parIn[WIDTH-1]`.
- R2: When `clkEnN` is 0 and `loadN` is 1 at a rising edge, stage 0 takes `serIn` and each stage i takes the old stage i-1.
- R3: When `clkEnN` is 1 at a rising edge, the register keeps its contents, whatever `loadN`, `serIn` and `parIn` are.
- R4: A 0 on `rstN` clears every stage to 0 at once, without waiting for a clock edge.
- R5: While `rstN` is 0, clock edges with a load or shift request leave the register cleared. Reset takes priority over the enable, and the enable takes priority over the load/shift choice.
- R6: After a load followed by WIDTH-1 enabled shifts, `serOut` presents `parIn[WIDTH-1]` down to `parIn[0]`, one bit per cycle. After the WIDTH-th shift it presents the first serial bit that was shifted in.
- R7: Two units chained through `serOut` to `serIn`, with shared controls, behave as one register of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; the register updates on the rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| clkEnN | input | 1 | Synchronous enable, active low; when high the register holds |
| loadN | input | 1 | 0 selects parallel load, 1 selects serial shift |
| serIn | input | 1 | Serial data into stage 0 |
| parIn | input | WIDTH | Parallel word; bit i goes to stage i |
| serOut | output | 1 | The last stage |

## Verification
The bench checks the serialization order bit by bit after a load. A design with reversed shift direction, or with a mirrored parallel mapping, would emit the word backwards.

The bench also applies hold cycles with a load request pending. A design that ignored the enable, or that honoured load over the enable, would change `serOut`.

Reset is dropped in the middle of a shift and away from any clock edge, and clock edges with load requests follow while reset is held low. A design with a synchronous clear would keep its old output until the next edge, and a design with the wrong priority would reload.

Finally, a two-unit chain is compared against a 16-bit model, which exposes any off-by-one in the bit that leaves the last stage.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // strobes from control to datapath; at most one is set per cycle
  typedef struct packed {
    logic load;
    logic shift;
  } pisoStrobe_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic        clkEnN,
  input  logic        loadN,
  output pisoStrobe_t strobe
);
  // enable outranks the load/shift choice
  always_comb begin
    strobe.load  = !clkEnN && !loadN;
    strobe.shift = !clkEnN &&  loadN;
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pisoStrobe_t      strobe,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stages
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shifted;

  generate
    if (WIDTH > 1) begin : g_multi
      assign shifted = {stages[LAST-1:0], serIn};
    end else begin : g_single
      assign shifted = serIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             stages <= '0;
    else if (strobe.load)  stages <= parIn;
    else if (strobe.shift) stages <= shifted;
  end
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic             loadN,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut
);
  localparam int LAST = WIDTH - 1;

  pisoStrobe_t      strobe;
  logic [WIDTH-1:0] stages;

  piso_ctrl u_ctrl (
    .clkEnN (clkEnN),
    .loadN  (loadN),
    .strobe (strobe)
  );

  piso_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .serIn  (serIn),
    .parIn  (parIn),
    .stages (stages)
  );

  assign serOut = stages[LAST];
endmodule

// File: rtl/piso_shreg_chk.sv
module piso_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEnN,
  input logic             loadN,
  input logic             serIn,
  input logic [WIDTH-1:0] parIn,
  input logic             serOut,
  input logic [WIDTH-1:0] stages
);
  localparam int LAST = WIDTH - 1;

  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !loadN) |=> (stages == $past(parIn) && serOut == $past(parIn[LAST])));

  generate
    if (WIDTH > 1) begin : g_shiftChk
      p_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
        (!clkEnN && loadN) |=> (stages == {$past(stages[LAST-1:0]), $past(serIn)}));
    end
  endgenerate

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(stages) && $stable(serOut)));

  // R4 / R5: cleared whenever reset is sampled low, whatever the controls
  p_clear_r4: assert property (@(posedge clk)
    !rstN |-> (stages == '0 && !serOut));
endmodule

bind piso_shreg piso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .clkEnN (clkEnN),
  .loadN  (loadN),
  .serIn  (serIn),
  .parIn  (parIn),
  .serOut (serOut),
  .stages (stages)
);

// File: tb/piso_shreg_test.sv
module piso_shreg_test;
  localparam int PERIOD = 10;
  localparam int W      = 8;
  localparam int NVEC   = 11;

  // {loadN, clkEnN, serIn, parIn, expected serOut of the first unit}
  typedef struct packed {
    logic         loadN;
    logic         clkEnN;
    logic         serIn;
    logic [W-1:0] par;
    logic         exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 8'hA5, 1'b1},   // R1 load A5
    '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0},   // R2 shift -> 4A
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b1},   // R2 shift -> 95
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1},   // R3 hold, load pending
    '{1'b1, 1'b1, 1'b0, 8'h00, 1'b1},   // R3 hold, shift pending
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0},   // R2 shift -> 2B
    '{1'b0, 1'b0, 1'b0, 8'h7F, 1'b0},   // R1 load 7F
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b1},   // R2 shift -> FF
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1},   // R3 hold
    '{1'b0, 1'b0, 1'b0, 8'h80, 1'b1},   // R1 load 80
    '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0}    // R2 shift -> 00
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b1;
  logic         clkEnN = 1'b1;
  logic         loadN = 1'b1;
  logic         serIn = 1'b0;
  logic [W-1:0] parA = '0;
  logic [W-1:0] parB = '0;
  logic         outA;
  logic         outB;
  logic [2*W-1:0] model = '0;
  int           nRun = 0;
  int           nFail = 0;
  bit           done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  piso_shreg #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN),
    .serIn(serIn), .parIn(parA), .serOut(outA));

  piso_shreg #(.WIDTH(W)) uut2 (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN),
    .serIn(outA), .parIn(parB), .serOut(outB));

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // apply controls, update the 16-bit model, clock once, sample mid-cycle
  task automatic tick(input logic ld, input logic en, input logic s,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    loadN = ld; clkEnN = en; serIn = s; parA = a; parB = b;
    if (rstN) begin
      if (!en && !ld)     model = {b, a};
      else if (!en && ld) model = {model[2*W-2:0], s};
    end
    @(posedge clk);
    #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #1 rstN = 1'b0;
    @(posedge clk); #(PERIOD/4);
    check("R4 reset A", outA, 1'b0);
    check("R4 reset B", outB, 1'b0);
    rstN = 1'b1;
    model = '0;

    // table walk; R7 cascade compared against the 16-bit model
    for (int i = 0; i < NVEC; i++) begin
      tick(VECS[i].loadN, VECS[i].clkEnN, VECS[i].serIn, VECS[i].par,
           VECS[i].par ^ 8'h3C);
      check("R1/R2/R3 table", outA, VECS[i].exp);
      check("R7 chain", outB, model[2*W-1]);
    end

    // R6 order: load CA, then D7..D0, then first serial bit (1)
    begin
      logic [W-1:0] word = 8'hCA;
      tick(1'b0, 1'b0, 1'b0, word, 8'h00);
      check("R6 D7", outA, word[W-1]);
      for (int k = 1; k < W; k++) begin
        tick(1'b1, 1'b0, (k == 1), 8'h00, 8'h00);
        check("R6 order", outA, word[W-1-k]);
      end
      tick(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
      check("R6 fill", outA, 1'b1);
    end

    // R4 async clear mid-shift, away from any edge
    tick(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
    tick(1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
    tick(1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
    check("R4 pre", outA, 1'b1);
    #1 rstN = 1'b0;
    #1;
    check("R4 async A", outA, 1'b0);
    check("R4 async B", outB, 1'b0);

    // R5 load requests under reset are ignored
    tick(1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF);
    tick(1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF);
    check("R5 reset priority A", outA, 1'b0);
    check("R5 reset priority B", outB, 1'b0);
    rstN = 1'b1;
    model = '0;
    tick(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    check("R5 still clear", outA, 1'b0);

    // R7 full 16-bit run through the chain
    tick(1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3);
    check("R7 load B", outB, model[2*W-1]);
    for (int k = 0; k < 2*W + 2; k++) begin
      tick(1'b1, (k == 5), k[0] ^ k[2], 8'h00, 8'h00);
      check("R7 chain shift B", outB, model[2*W-1]);
      check("R7 chain shift A", outA, model[W-1]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule